// File: doc/BRIEF.md
# E1 Register-Sourced CAS Multiframe Generator

This block produces the time slot 16 channel-associated signaling content for an E1 transmitter. A processor loads a bank of sixteen byte registers through a simple write port. An external frame and slot counter marks the position in the 16-frame signaling multiframe. In slot 16 of every frame the block emits the byte of the register that belongs to that frame. All other slots pass through untouched.

Register writes always land in a shadow bank. The whole shadow bank is copied into the active bank at the multiframe boundary, so one multiframe never mixes old and new signaling. The frame 0 byte carries the multiframe alignment pattern: the upper nibble is forced to zero and the lower nibble holds the spare and alarm bits from register 1. Other frames carry two channels' ABCD nibbles each.

The generated byte can be placed on the line-side stream or on the system-side stream. On the system side it takes priority over an externally supplied serial signaling byte. When both register signaling and external signaling are off, both streams pass through unchanged. A one-cycle pulse marks the start of each multiframe so software can time its updates.

Top module: `e1_cas_mf_gen`

## Requirements
- R1: While reset is low, `sys_o`, `line_o` and `mf_start_o` are 0. After reset every register in both banks holds 8'hFF, so the first multiframe's slot 16 bytes are 8'hFF, and 8'h0F in frame 0.
- R2: Both outputs are registered. `sys_o` and `line_o` show, one clock later, the `sys_i` and `line_i` bytes of any slot other than 16, unchanged.
- R3: With `sig_en_i`=1, slot 16 of frame f (1..15) carries the active byte of write address f (register f+1), with bits [7:4] and [3:0] each holding one channel's ABCD.
- R4: With `sig_en_i`=1, slot 16 of frame 0 carries bits [7:4]=4'b0000 and bits [3:0] equal to bits [3:0] of the active byte at write address 0.
- R5: A write (`wr_en_i`=1, address 0..15) updates only the shadow bank. The shadow bank is copied to the active bank on the cycle whose inputs are frame 0, slot 0. That copy uses the shadow contents from before any write made in the same cycle.
- R6: `sig_side_i`=0 places the register byte on `line_o`. `sig_side_i`=1 places it on `sys_o`. The other stream is not given the register byte.
- R7: With `ext_sig_en_i`=1, and register signaling off or directed to the line side, `sys_o` in slot 16 carries `ext_sig_i`.
- R8: With `sig_en_i`=1 and `sig_side_i`=1, the register byte replaces slot 16 on `sys_o` even when `ext_sig_en_i`=1.
- R9: With `sig_en_i`=0 and `ext_sig_en_i`=0, every slot including 16 passes unaltered on both streams.
- R10: `mf_start_o` is high for exactly the clock in which the outputs show frame 0, slot 0, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock, one time slot per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 4 | Frame number within the multiframe (0..15) |
| slot_i | input | 5 | Time slot number within the frame (0..31) |
| sys_i | input | 8 | System-side byte stream in |
| line_i | input | 8 | Line-side byte stream in |
| ext_sig_en_i | input | 1 | Enables external serial signaling on the system side |
| ext_sig_i | input | 8 | External signaling byte for the current slot 16 |
| sig_en_i | input | 1 | Enables register-sourced signaling |
| sig_side_i | input | 1 | 0: line-side insertion, 1: system-side insertion |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address (0 = register 1) |
| wr_data_i | input | 8 | Register write data |
| sys_o | output | 8 | System-side byte stream out |
| line_o | output | 8 | Line-side byte stream out |
| mf_start_o | output | 1 | Multiframe start pulse |

## Verification
The bench rewrites all registers in the middle of each multiframe. It checks that the multiframe in progress keeps its old bytes and that the next one picks up the new ones. A design that copied shadow to active on every write would show the new bytes at once.

A write placed on the boundary cycle itself must wait a full extra multiframe. A copy that took the freshly written value would show up one multiframe early.

Frame 0 is checked against register contents whose upper nibble is nonzero, which exposes a missing alignment-pattern force. Runs with external signaling enabled together with system-side insertion catch a wrong priority order. Runs with line-side insertion catch a byte that leaks onto the wrong stream.

// File: rtl/e1_cas_pkg.sv
package e1_cas_pkg;
  typedef enum logic {
    SIDE_LINE = 1'b0,
    SIDE_SYS  = 1'b1
  } side_e;
endpackage

// File: rtl/cas_reg_bank.sv
module cas_reg_bank #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '1,
  localparam int unsigned AW = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic [AW-1:0]     rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] shadow_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] active_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[i] <= RST_VAL;
      end else if (wr_en_i && wr_addr_i == AW'(i)) begin
        shadow_q[i] <= wr_data_i;
      end
    end

    // copy takes pre-write shadow value
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        active_q[i] <= RST_VAL;
      end else if (load_i) begin
        active_q[i] <= shadow_q[i];
      end
    end
  end

  assign rd_data_o = active_q[rd_idx_i];

  p_active_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(active_q));
  p_active_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> active_q == $past(shadow_q));
endmodule

// File: rtl/cas_mf_timing.sv
module cas_mf_timing #(
  parameter int unsigned FRAME_W  = 4,
  parameter int unsigned SLOT_W   = 5,
  parameter int unsigned SIG_SLOT = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [SLOT_W-1:0]  slot_i,
  output logic               sig_slot_o,
  output logic               mfas_frame_o,
  output logic               mf_load_o,
  output logic               mf_start_o
);
  assign sig_slot_o   = (slot_i == SLOT_W'(SIG_SLOT));
  assign mfas_frame_o = (frame_i == '0);
  assign mf_load_o    = mfas_frame_o && (slot_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mf_start_o <= 1'b0;
    else         mf_start_o <= mf_load_o;
  end

  p_mf_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i == '0 && slot_i == '0) |=> mf_start_o);
  p_mf_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_i == '0 && slot_i == '0) |=> !mf_start_o);
endmodule

// File: rtl/cas_slot_mux.sv
module cas_slot_mux
  import e1_cas_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HALF  = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sig_slot_i,
  input  logic              mfas_i,
  input  logic [DATA_W-1:0] reg_byte_i,
  input  logic              sig_en_i,
  input  side_e             side_i,
  input  logic              ext_en_i,
  input  logic [DATA_W-1:0] ext_i,
  input  logic [DATA_W-1:0] sys_i,
  input  logic [DATA_W-1:0] line_i,
  output logic [DATA_W-1:0] sys_o,
  output logic [DATA_W-1:0] line_o
);
  logic [DATA_W-1:0] sig_byte;
  logic [DATA_W-1:0] sys_d, line_d;
  logic              reg_sys, reg_line;

  // frame 0: alignment pattern forces upper nibble to zero
  assign sig_byte = mfas_i ? {{(DATA_W-HALF){1'b0}}, reg_byte_i[HALF-1:0]} : reg_byte_i;
  assign reg_sys  = sig_en_i && (side_i == SIDE_SYS);
  assign reg_line = sig_en_i && (side_i == SIDE_LINE);

  always_comb begin
    sys_d  = sys_i;
    line_d = line_i;
    if (sig_slot_i) begin
      if (reg_sys)       sys_d = sig_byte;   // register beats external
      else if (ext_en_i) sys_d = ext_i;
      if (reg_line)      line_d = sig_byte;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_o  <= '0;
      line_o <= '0;
    end else begin
      sys_o  <= sys_d;
      line_o <= line_d;
    end
  end

  p_other_slots_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_slot_i |=> (sys_o == $past(sys_i) && line_o == $past(line_i)));
  p_passthru_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sig_en_i && !ext_en_i) |=> (sys_o == $past(sys_i) && line_o == $past(line_i)));
  p_mfas_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_slot_i && mfas_i && sig_en_i && side_i == SIDE_LINE) |=> line_o[DATA_W-1:HALF] == '0);
  p_mfas_sys_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_slot_i && mfas_i && sig_en_i && side_i == SIDE_SYS) |=> sys_o[DATA_W-1:HALF] == '0);
  p_override_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_slot_i && !mfas_i && sig_en_i && side_i == SIDE_SYS && ext_en_i)
      |=> sys_o == $past(reg_byte_i));
  p_line_untouched_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (side_i == SIDE_SYS) |=> line_o == $past(line_i));
endmodule

// File: rtl/e1_cas_mf_gen.sv
module e1_cas_mf_gen
  import e1_cas_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned SLOTS    = 32,
  parameter int unsigned SIG_SLOT = 16,
  parameter int unsigned DATA_W   = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '1,
  localparam int unsigned FW = $clog2(NUM_REGS),
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FW-1:0]     frame_i,
  input  logic [SW-1:0]     slot_i,
  input  logic [DATA_W-1:0] sys_i,
  input  logic [DATA_W-1:0] line_i,
  input  logic              ext_sig_en_i,
  input  logic [DATA_W-1:0] ext_sig_i,
  input  logic              sig_en_i,
  input  logic              sig_side_i,
  input  logic              wr_en_i,
  input  logic [FW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] sys_o,
  output logic [DATA_W-1:0] line_o,
  output logic              mf_start_o
);
  logic              sig_slot, mfas_frame, mf_load;
  logic [DATA_W-1:0] reg_byte;

  cas_mf_timing #(
    .FRAME_W (FW),
    .SLOT_W  (SW),
    .SIG_SLOT(SIG_SLOT)
  ) u_timing (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_i     (frame_i),
    .slot_i      (slot_i),
    .sig_slot_o  (sig_slot),
    .mfas_frame_o(mfas_frame),
    .mf_load_o   (mf_load),
    .mf_start_o  (mf_start_o)
  );

  cas_reg_bank #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .RST_VAL (RST_VAL)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .load_i   (mf_load),
    .rd_idx_i (frame_i),
    .rd_data_o(reg_byte)
  );

  cas_slot_mux #(
    .DATA_W(DATA_W)
  ) u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sig_slot_i(sig_slot),
    .mfas_i    (mfas_frame),
    .reg_byte_i(reg_byte),
    .sig_en_i  (sig_en_i),
    .side_i    (side_e'(sig_side_i)),
    .ext_en_i  (ext_sig_en_i),
    .ext_i     (ext_sig_i),
    .sys_i     (sys_i),
    .line_i    (line_i),
    .sys_o     (sys_o),
    .line_o    (line_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (sys_o == '0 && line_o == '0 && !mf_start_o));
endmodule

// File: tb/e1_cas_mf_gen_tb.sv
module e1_cas_mf_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] frame_i = '0;
  logic [4:0] slot_i = '0;
  logic [7:0] sys_i = '0, line_i = '0, ext_sig_i = '0, wr_data_i = '0;
  logic       ext_sig_en_i = 1'b0, sig_en_i = 1'b0, sig_side_i = 1'b0, wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] sys_o, line_o;
  logic       mf_start_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] sh_m [16];
  logic [7:0] act_m [16];

  // row: {sig_en, side, ext_en, seed}
  localparam logic [10:0] ROWS [6] = '{
    {1'b1, 1'b0, 1'b0, 8'h11},
    {1'b1, 1'b1, 1'b0, 8'h2C},
    {1'b1, 1'b1, 1'b1, 8'h47},
    {1'b1, 1'b0, 1'b1, 8'h63},
    {1'b0, 1'b0, 1'b1, 8'h9A},
    {1'b0, 1'b0, 1'b0, 8'hD5}
  };

  e1_cas_mf_gen u_dut (
    .clk_i, .rst_ni, .frame_i, .slot_i, .sys_i, .line_i,
    .ext_sig_en_i, .ext_sig_i, .sig_en_i, .sig_side_i,
    .wr_en_i, .wr_addr_i, .wr_data_i, .sys_o, .line_o, .mf_start_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int f, int ts);
    string t;
    if (ts != 16) return (!sig_en_i && !ext_sig_en_i) ? "R9" : "R2";
    if (!sig_en_i) return ext_sig_en_i ? "R7" : "R9";
    t = (f == 0) ? "R4 R5 R6" : "R3 R5 R6";
    if (sig_side_i && ext_sig_en_i) t = {t, " R8"};
    else if (ext_sig_en_i) t = {t, " R7"};
    return t;
  endfunction

  // one slot: drive, model, wait an edge, compare at negedge
  task automatic slot_step(int f, int ts, bit we, logic [3:0] wa, logic [7:0] wd);
    logic [7:0] sig, e_sys, e_line;
    logic       e_mf;
    string      t;
    frame_i = 4'(f); slot_i = 5'(ts);
    sys_i  = {4'(f), 4'(ts)} ^ 8'h3C;
    line_i = {4'(ts), 4'(f)} ^ 8'hC3;
    ext_sig_i = 8'hB0 | 8'(f);
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    if (f == 0 && ts == 0) for (int i = 0; i < 16; i++) act_m[i] = sh_m[i];
    if (we) sh_m[wa] = wd;
    sig = (f == 0) ? {4'h0, act_m[0][3:0]} : act_m[f];
    e_sys = sys_i; e_line = line_i;
    if (ts == 16) begin
      if (sig_en_i && sig_side_i) e_sys = sig;
      else if (ext_sig_en_i) e_sys = ext_sig_i;
      if (sig_en_i && !sig_side_i) e_line = sig;
    end
    e_mf = (f == 0 && ts == 0);
    t = tag_of(f, ts);
    @(negedge clk_i);
    check({t, " sys"}, sys_o, e_sys);
    check({t, " line"}, line_o, e_line);
    check("R10 mf_start", {7'd0, mf_start_o}, {7'd0, e_mf});
  endtask

  task automatic run_mf(bit do_wr, logic [7:0] seed, bit bnd_wr, logic [7:0] bnd_data);
    for (int f = 0; f < 16; f++)
      for (int ts = 0; ts < 32; ts++) begin
        if (bnd_wr && f == 0 && ts == 0)
          slot_step(f, ts, 1'b1, 4'd0, bnd_data);
        else if (do_wr && f == 3 && ts < 16)
          slot_step(f, ts, 1'b1, 4'(ts), seed ^ 8'(ts * 8'h1B));
        else
          slot_step(f, ts, 1'b0, 4'd0, 8'h00);
      end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin sh_m[i] = 8'hFF; act_m[i] = 8'hFF; end
    repeat (3) @(negedge clk_i);
    check("R1 reset sys", sys_o, 8'h00);
    check("R1 reset line", line_o, 8'h00);
    check("R1 reset mf", {7'd0, mf_start_o}, 8'h00);
    rst_ni = 1'b1;

    // R1: first multiframe shows reset contents (0xFF, frame 0 -> 0x0F)
    sig_en_i = 1'b1; sig_side_i = 1'b0;
    run_mf(1'b0, 8'h00, 1'b0, 8'h00);

    // R5: mid-multiframe writes, then boundary write waits a full multiframe
    foreach (ROWS[r]) begin
      sig_en_i = ROWS[r][10]; sig_side_i = ROWS[r][9]; ext_sig_en_i = ROWS[r][8];
      run_mf(1'b1, ROWS[r][7:0], 1'b0, 8'h00);
    end
    sig_en_i = 1'b1; sig_side_i = 1'b1; ext_sig_en_i = 1'b0;
    run_mf(1'b0, 8'h00, 1'b1, 8'hE7);
    run_mf(1'b0, 8'h00, 1'b0, 8'h00);
    sig_side_i = 1'b0;
    run_mf(1'b0, 8'h00, 1'b0, 8'h00);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule